// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, A and B, through a pair of storage registers, one for each direction. The A-to-B register samples the A bus on the rising edge of its own clock. The B-to-A register samples the B bus on the rising edge of a second, unrelated clock. On the way out, each direction picks one of two sources for the data it drives onto the far bus: the live value on the near bus, or the value held in that direction's register.

An active-low output enable and a direction input decide which bus is driven, if either is. When the enable is high the block is isolated and drives neither bus. The registers still capture in that state. Each bus is modelled as a separate input, output and output-enable signal, so the design needs no internal tri-states. Pad buffers outside the block combine the three signals.

A build-time parameter chooses between a straight data path and an inverting one. Inversion applies only to the data placed on the driven bus, never to the stored value.

Top module: `regxcvr_top`

## Requirements
- R1: After the active-low reset `rst_n` is asserted, both registers hold zero. This is observable by selecting the stored source (select = 1) with the outputs enabled.
- R2: On each rising edge of `clk_ab`, the A-to-B register loads `a_in`. On each rising edge of `clk_ba`, the B-to-A register loads `b_in`. Each register changes only on its own clock.
- R3: When `oe_n` is 1 (isolation), `a_oe` and `b_oe` are both 0.
- R4: When `oe_n` is 0, `dir_a2b` = 1 gives `b_oe` = 1 and `a_oe` = 0, and `dir_a2b` = 0 gives `a_oe` = 1 and `b_oe` = 0. `a_oe` and `b_oe` are never 1 together.
- R5: While `b_oe` is 1, `b_out` carries `a_in` when `sel_ab` = 0 and the A-to-B register when `sel_ab` = 1.
- R6: While `a_oe` is 1, `a_out` carries `b_in` when `sel_ba` = 0 and the B-to-A register when `sel_ba` = 1.
- R7: Captures into either register, or both, happen in isolation mode and while a bus is driven. Changes on the bus inputs with no clock edge leave the stored values unchanged.
- R8: With `INVERT` = 1, every bit of the driven data is the complement of the selected source. With `INVERT` = 0 it is the source unchanged.
- R9: The driven data follows its source combinationally. A register update shows on the bus in the same cycle as the capturing clock edge.
- R10: An output whose enable is 0 carries all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of both registers |
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| oe_n | input | 1 | Active-low output enable; 1 isolates both buses |
| dir_a2b | input | 1 | 1: drive B from the A side; 0: drive A from the B side |
| sel_ab | input | 1 | A-to-B source: 0 live A, 1 stored register |
| sel_ba | input | 1 | B-to-A source: 0 live B, 1 stored register |
| a_in | input | WIDTH | Value seen on bus A |
| a_out | output | WIDTH | Data to drive onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | WIDTH | Value seen on bus B |
| b_out | output | WIDTH | Data to drive onto bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The hardest case to reach from the ports is the interleaving of the two clock domains with the output controls. This covers a capture on one clock while the other direction is driving or the block is isolated, and a stored value being read out after many input changes with no edge in between. The bench gates each capture clock off a common base clock with its own random enable, so edges fall on one clock, the other or both. It also walks every combination of enable, direction and the two selects. The outputs are compared just before each new stimulus and again just after it, which catches a same-cycle register update as well as a combinational source change.

// File: rtl/regxcvr_pkg.sv
package regxcvr_pkg;

    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_sel_e;

    typedef struct packed {
        logic a_en;
        logic b_en;
    } drive_t;

endpackage

// File: rtl/regxcvr_capture.sv
module regxcvr_capture #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    typedef struct packed {
        logic [WIDTH-1:0] data;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d      = cap_q;
        cap_d.data = d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign q = cap_q.data;
endmodule

// File: rtl/regxcvr_path.sv
module regxcvr_path
    import regxcvr_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] stored,
    input  src_sel_e         sel,
    input  logic             en,
    output logic [WIDTH-1:0] data_out
);
    logic [WIDTH-1:0] src;
    logic [WIDTH-1:0] shaped;

    always_comb begin
        src = (sel == SRC_STORED) ? stored : live;
    end

    generate
        if (INVERT) begin : g_inv
            assign shaped = ~src;
        end else begin : g_pass
            assign shaped = src;
        end
    endgenerate

    always_comb begin
        data_out = en ? shaped : '0;
    end
endmodule

// File: rtl/regxcvr_drive.sv
module regxcvr_drive
    import regxcvr_pkg::*;
(
    input  logic   oe_n,
    input  logic   dir_a2b,
    output drive_t drv
);
    always_comb begin
        drv      = '0;
        drv.b_en = !oe_n &&  dir_a2b;
        drv.a_en = !oe_n && !dir_a2b;
    end
endmodule

// File: rtl/regxcvr_top.sv
module regxcvr_top
    import regxcvr_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic             rst_n,
    input  logic             clk_ab,
    input  logic             clk_ba,
    input  logic             oe_n,
    input  logic             dir_a2b,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);
    logic [WIDTH-1:0] ab_store_q;
    logic [WIDTH-1:0] ba_store_q;
    drive_t           drv;

    regxcvr_capture #(.WIDTH(WIDTH)) u_cap_ab (
        .clk(clk_ab), .rst_n(rst_n), .d(a_in), .q(ab_store_q)
    );

    regxcvr_capture #(.WIDTH(WIDTH)) u_cap_ba (
        .clk(clk_ba), .rst_n(rst_n), .d(b_in), .q(ba_store_q)
    );

    regxcvr_drive u_drive (
        .oe_n(oe_n), .dir_a2b(dir_a2b), .drv(drv)
    );

    regxcvr_path #(.WIDTH(WIDTH), .INVERT(INVERT)) u_path_ab (
        .live(a_in), .stored(ab_store_q), .sel(src_sel_e'(sel_ab)),
        .en(drv.b_en), .data_out(b_out)
    );

    regxcvr_path #(.WIDTH(WIDTH), .INVERT(INVERT)) u_path_ba (
        .live(b_in), .stored(ba_store_q), .sel(src_sel_e'(sel_ba)),
        .en(drv.a_en), .data_out(a_out)
    );

    assign a_oe = drv.a_en;
    assign b_oe = drv.b_en;
endmodule

// File: rtl/regxcvr_checker.sv
module regxcvr_checker #(
    parameter int WIDTH  = 8,
    parameter bit INVERT = 1'b0
) (
    input logic             rst_n,
    input logic             clk_ab,
    input logic             clk_ba,
    input logic             oe_n,
    input logic             dir_a2b,
    input logic             sel_ab,
    input logic             sel_ba,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] a_out,
    input logic [WIDTH-1:0] b_out,
    input logic             a_oe,
    input logic             b_oe,
    input logic [WIDTH-1:0] ab_store,
    input logic [WIDTH-1:0] ba_store
);
    localparam logic [WIDTH-1:0] MASK = INVERT ? '1 : '0;

    logic armed_ab, armed_ba;

    always_ff @(posedge clk_ab or negedge rst_n) begin
        if (!rst_n) armed_ab <= 1'b0;
        else        armed_ab <= 1'b1;
    end

    always_ff @(posedge clk_ba or negedge rst_n) begin
        if (!rst_n) armed_ba <= 1'b0;
        else        armed_ba <= 1'b1;
    end

    assert_cap_ab_R2: assert property (@(posedge clk_ab) disable iff (!rst_n)
        armed_ab |-> ab_store == $past(a_in));

    assert_cap_ba_R2: assert property (@(posedge clk_ba) disable iff (!rst_n)
        armed_ba |-> ba_store == $past(b_in));

    assert_isolate_R3: assert property (@(posedge clk_ab) disable iff (!rst_n)
        oe_n |-> (!a_oe && !b_oe));

    assert_exclusive_R4: assert property (@(posedge clk_ba) disable iff (!rst_n)
        !(a_oe && b_oe));

    assert_dir_R4: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (!oe_n && dir_a2b) |-> b_oe);

    assert_live_b_R5: assert property (@(posedge clk_ba) disable iff (!rst_n)
        (b_oe && !sel_ab) |-> b_out == (a_in ^ MASK));

    assert_live_a_R6: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (a_oe && !sel_ba) |-> a_out == (b_in ^ MASK));

    assert_idle_R10: assert property (@(posedge clk_ab) disable iff (!rst_n)
        !a_oe |-> a_out == '0);

    assert_stored_R5: assert property (@(posedge clk_ba) disable iff (!rst_n)
        (b_oe && sel_ab) |-> b_out == (ab_store ^ MASK));

    assert_stored_R6: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (a_oe && sel_ba && !dir_a2b) |-> a_out == (ba_store ^ MASK));
endmodule

bind regxcvr_top regxcvr_checker #(.WIDTH(WIDTH), .INVERT(INVERT)) u_chk (
    .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba), .oe_n(oe_n),
    .dir_a2b(dir_a2b), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out),
    .a_oe(a_oe), .b_oe(b_oe), .ab_store(ab_store_q), .ba_store(ba_store_q)
);

// File: tb/test_regxcvr_top.sv
`timescale 1ns/1ps
module test_regxcvr_top;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_ab = 1'b0, en_ba = 1'b0;
    logic oe_n = 1'b1, dir_a2b = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;

    logic [W-1:0] a_out0, b_out0, a_out1, b_out1;
    logic a_oe0, b_oe0, a_oe1, b_oe1;

    logic clk_ab, clk_ba;
    assign clk_ab = clk & en_ab;
    assign clk_ba = clk & en_ba;

    always #5 clk = ~clk;

    int vectors = 0;
    int fails   = 0;

    logic [W-1:0] m_ab = '0, m_ba = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ab <= '0;
            m_ba <= '0;
        end else begin
            if (en_ab) m_ab <= a_in;
            if (en_ba) m_ba <= b_in;
        end
    end

    regxcvr_top #(.WIDTH(W), .INVERT(1'b0)) i_regxcvr_top (
        .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba), .oe_n(oe_n),
        .dir_a2b(dir_a2b), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_in(a_in), .a_out(a_out0), .a_oe(a_oe0),
        .b_in(b_in), .b_out(b_out0), .b_oe(b_oe0)
    );

    regxcvr_top #(.WIDTH(W), .INVERT(1'b1)) i_regxcvr_top_inv (
        .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba), .oe_n(oe_n),
        .dir_a2b(dir_a2b), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_in(a_in), .a_out(a_out1), .a_oe(a_oe1),
        .b_in(b_in), .b_out(b_out1), .b_oe(b_oe1)
    );

    task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    task automatic compare();
        logic exp_a_oe, exp_b_oe;
        logic [W-1:0] src_b, src_a;
        exp_b_oe = !oe_n &&  dir_a2b;
        exp_a_oe = !oe_n && !dir_a2b;
        src_b = sel_ab ? m_ab : a_in;
        src_a = sel_ba ? m_ba : b_in;
        chk({7'd0, a_oe0}, {7'd0, exp_a_oe}, "R3 R4 a_oe");
        chk({7'd0, b_oe0}, {7'd0, exp_b_oe}, "R3 R4 b_oe");
        chk({7'd0, a_oe0 & b_oe0}, 8'd0, "R4 exclusive");
        chk(b_out0, exp_b_oe ? src_b : '0, "R5 R9 R10 b_out");
        chk(a_out0, exp_a_oe ? src_a : '0, "R6 R9 R10 a_out");
        chk(b_out1, exp_b_oe ? ~src_b : '0, "R8 R5 b_out inverted");
        chk(a_out1, exp_a_oe ? ~src_a : '0, "R8 R6 a_out inverted");
    endtask

    task automatic cyc(input logic oe, input logic dir, input logic sab, input logic sba,
                       input logic [W-1:0] av, input logic [W-1:0] bv,
                       input logic eab, input logic eba);
        @(negedge clk);
        compare();
        oe_n = oe; dir_a2b = dir; sel_ab = sab; sel_ba = sba;
        a_in = av; b_in = bv; en_ab = eab; en_ba = eba;
        #1;
        compare();
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: stored source right after reset reads zero
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 8'hA5, 8'h3C, 1'b0, 1'b0);
        chk(b_out0, 8'h00, "R1 reset A-to-B register");
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 8'hA5, 8'h3C, 1'b0, 1'b0);
        chk(a_out0, 8'h00, "R1 reset B-to-A register");

        // R2 R7: capture in isolation, one clock at a time then both
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 8'h11, 8'h22, 1'b1, 1'b0);
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 8'h33, 8'h44, 1'b0, 1'b1);
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 8'h55, 8'h66, 1'b1, 1'b1);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 8'h77, 8'h88, 1'b0, 1'b0);
        chk(b_out0, 8'h55, "R7 isolation capture A-to-B");
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 8'h99, 8'hAA, 1'b0, 1'b0);
        chk(a_out0, 8'h66, "R7 isolation capture B-to-A");

        // R7: stored values hold across live input changes with no edge
        for (int i = 0; i < 20; i++) begin
            cyc(1'b0, i[0], 1'b1, 1'b1, 8'(i * 37), 8'(i * 91), 1'b0, 1'b0);
            if (i[0]) chk(b_out0, 8'h55, "R7 A-to-B holds without edge");
            else      chk(a_out0, 8'h66, "R7 B-to-A holds without edge");
        end

        // R9: capture while driving, new value visible in the same cycle
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 8'hC3, 8'h5A, 1'b1, 1'b1);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 8'h0F, 8'hF0, 1'b0, 1'b0);
        chk(b_out0, 8'hC3, "R9 R2 stored update while driving");

        // R3 R4 R5 R6: every control combination with random data and edges
        for (int rep = 0; rep < 40; rep++) begin
            for (int c = 0; c < 16; c++) begin
                cyc(c[3], c[2], c[1], c[0], 8'($urandom), 8'($urandom),
                    1'($urandom), 1'($urandom));
            end
        end

        @(negedge clk);
        compare();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule